// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block produces the MAC-side RGMII transmit clock from one of two fast parent sources. Everything runs on a single system clock; each parent source is presented as a tick strobe that is high in the system cycles where that parent has an edge. A 32-bit configuration word, loaded through a plain write port, picks the parent. It also sets a one-based integer divisor, a transmit phase delay and an output enable. The clock path is: parent select, divider, a hidden halving stage, a speed stage driven by the MAC's line-speed code, a phase-delay tap and an output gate.

Software programs the divider once for the gigabit rate. The speed stage then scales the output to one fifth or one fiftieth of that rate when the MAC reports a slower link, with no further writes. Setting changes are held back until a clean waveform boundary, so the emitted clock never shows a shortened pulse. A valid flag reports when the first complete output period has been produced after enabling.

Top module: `rgmii_txclk_gen`

## Requirements
- R1: A cycle with `wr_en` high loads `wr_data` into the 32-bit configuration word. Bit 4 chooses the parent: 0 takes ticks from `par0_tick`, 1 takes ticks from `par1_tick`. Bits outside 10:4 have no effect.
- R2: Bits 9:7 hold a one-based divisor N. The divider emits one fast pulse per N selected-parent ticks. The hidden halving stage makes the gigabit output toggle once per fast pulse, so each output half period is N parent ticks.
- R3: A divisor field of 0 behaves exactly like 1.
- R4: While bit 10 is 0, `tx_clk` is held low once its current high phase ends.
- R5: `spd` selects a speed divisor D: 2'b00 gives 50 (10 Mbit/s), 2'b01 gives 5 (100 Mbit/s), 2'b10 and 2'b11 give 1 (gigabit). Each high and each low phase lasts D×N parent ticks, giving 50% duty. A new `spd` value takes effect with no register write.
- R6: Bits 6:5 hold a delay k from 0 to 3. The emitted clock lags the undelayed clock by k fast-pulse periods.
- R7: Parent select, divisor, speed code and delay are captured only when the undelayed clock starts a high phase. A phase already under way finishes with its old length.
- R8: The gate changes state only while the pre-gate clock is low. The first high phase after enabling, and the last high phase before disabling, have full length.
- R9: `clk_valid` rises in the cycle after the second rising edge of `tx_clk` seen since enabling. It is low in any cycle where the stored bit 10 is 0.
- R10: Synchronous active-low reset clears the configuration word. `tx_clk` and `clk_valid` are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Configuration word to load |
| par0_tick | input | 1 | Edge strobe of parent source 0 |
| par1_tick | input | 1 | Edge strobe of parent source 1 |
| spd | input | 2 | Line-speed code from the MAC |
| tx_clk | output | 1 | Gated transmit clock |
| clk_valid | output | 1 | Output clock has completed a full period |

## Verification
The bench changes the speed code in the middle of a high phase. A generator that applied it at once would produce a 4- or 5-cycle pulse where the current 10-cycle phase should finish. It also turns the output off in mid-pulse and on at arbitrary points. A gate without low-phase synchronisation would chop the first or last pulse. A zero divisor field is checked against a field of 1, since a naive counter would either stall or wrap to eight. The phase-delay setting is measured as the shift of rising edges against a free-running cycle count. The valid flag is timed to the exact cycle after the second rising edge, so an off-by-one period count shows up.

// File: rtl/rgmii_txclk_gen.sv
module rgmii_txclk_gen #(
  parameter int CFG_W    = 32,
  parameter int SEL_BIT  = 4,
  parameter int DLY_LSB  = 5,
  parameter int DIV_LSB  = 7,
  parameter int DIV_W    = 3,
  parameter int GATE_BIT = 10,
  parameter int GIG_DIV  = 1,
  parameter int MID_DIV  = 5,
  parameter int SLOW_DIV = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             par0_tick,
  input  logic             par1_tick,
  input  logic [1:0]       spd,
  output logic             tx_clk,
  output logic             clk_valid
);
  localparam int SC_W = $clog2(SLOW_DIV);

  logic [CFG_W-1:0] cfg_q;
  logic             a_sel;
  logic [DIV_W-1:0] a_div, dcnt, nlast;
  logic [1:0]       a_spd, a_dly, vst;
  logic [SC_W-1:0]  scnt, slast;
  logic [2:0]       hist;
  logic             raw, pre, g_act, tx_q;

  wire tick   = a_sel ? par1_tick : par0_tick;
  assign nlast = (a_div == '0) ? '0 : a_div - 1'b1;
  wire pulse  = tick && (dcnt >= nlast);
  wire wrap   = pulse && (scnt >= slast);
  wire commit = wrap && !raw;

  always_comb begin
    case (a_spd)
      2'b00:   slast = SC_W'(SLOW_DIV - 1);
      2'b01:   slast = SC_W'(MID_DIV - 1);
      default: slast = SC_W'(GIG_DIV - 1);
    endcase
  end

  always_comb begin
    case (a_dly)
      2'd0:    pre = raw;
      2'd1:    pre = hist[0];
      2'd2:    pre = hist[1];
      default: pre = hist[2];
    endcase
  end

  assign tx_clk    = pre & g_act;
  assign clk_valid = (vst == 2'd2) && cfg_q[GATE_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      a_sel <= 1'b0;
      a_div <= '0;
      a_spd <= 2'b00;
      a_dly <= 2'b00;
      dcnt  <= '0;
      scnt  <= '0;
      raw   <= 1'b0;
      hist  <= '0;
      g_act <= 1'b0;
      tx_q  <= 1'b0;
      vst   <= 2'd0;
    end else begin
      if (wr_en) cfg_q <= wr_data;
      if (tick) dcnt <= pulse ? '0 : dcnt + 1'b1;
      if (pulse) begin
        hist <= {hist[1:0], raw};
        scnt <= wrap ? '0 : scnt + 1'b1;
        if (wrap) raw <= ~raw;
      end
      if (commit) begin
        a_sel <= cfg_q[SEL_BIT];
        a_div <= cfg_q[DIV_LSB +: DIV_W];
        a_spd <= spd;
        a_dly <= cfg_q[DLY_LSB +: 2];
      end
      if (!pre) g_act <= cfg_q[GATE_BIT];
      tx_q <= tx_clk;
      if (!cfg_q[GATE_BIT]) vst <= 2'd0;
      else if (tx_clk && !tx_q && vst != 2'd2) vst <= vst + 1'b1;
    end
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (cfg_q == '0 && !tx_clk && !clk_valid));

  p_toggle_on_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(raw) |-> $past(pulse));

  p_rise_needs_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_clk) |-> $past(cfg_q[GATE_BIT]));

  p_gate_off_stays_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[GATE_BIT] && !tx_clk) |=> !tx_clk);

  p_commit_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(a_spd) || !$stable(a_div) || !$stable(a_dly) || !$stable(a_sel)) |-> $rose(raw));

  p_gate_change_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(g_act) |-> !$past(pre));

  p_valid_after_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_valid) |-> $past(tx_clk));
endmodule

// File: tb/rgmii_txclk_gen_tb.sv
module rgmii_txclk_gen_tb;
  localparam int LIM = 4000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic par0_tick = 1'b1, par1_tick = 1'b0;
  logic [1:0] spd = 2'b10;
  logic tx_clk, clk_valid;
  int n_chk = 0, n_bad = 0, cyc = 0, t3 = 0;

  rgmii_txclk_gen u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .par0_tick(par0_tick), .par1_tick(par1_tick), .spd(spd),
    .tx_clk(tx_clk), .clk_valid(clk_valid));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    t3 = (t3 == 2) ? 0 : t3 + 1;
    par1_tick <= (t3 == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input bit sel, input int n, input int dly, input bit gate);
    logic [31:0] w;
    w = {$urandom(), 4'h0};
    w[4] = sel; w[6:5] = 2'(dly); w[9:7] = 3'(n); w[10] = gate;
    return w;
  endfunction

  function automatic int exp_half(input bit sel, input int n, input logic [1:0] s);
    int d;
    d = (s == 2'b00) ? 50 : (s == 2'b01) ? 5 : 1;
    return d * ((n == 0) ? 1 : n) * (sel ? 3 : 1);
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    prev = tx_clk; ok = 0;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk);
      if (tx_clk && !prev) begin ok = 1; break; end
      prev = tx_clk;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    bit ok;
    hi = 0; lo = 0;
    wait_rise(ok);
    if (!ok) return;
    hi = 1;
    for (int i = 0; i < LIM; i++) begin @(negedge clk); if (tx_clk) hi++; else break; end
    lo = 1;
    for (int i = 0; i < LIM; i++) begin @(negedge clk); if (!tx_clk) lo++; else break; end
  endtask

  task automatic settle();
    int h, l;
    for (int i = 0; i < 3; i++) measure(h, l);
  endtask

  initial begin
    int hi, lo, e, ph0, ph1, ph3;
    bit ok, sel;
    int n, dly;
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    chk(!tx_clk && !clk_valid, "R10 reset outputs", int'(tx_clk) + int'(clk_valid), 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(!tx_clk, "R10 cleared word keeps gate off", int'(tx_clk), 0);

    // R1 R2 R5 R6: random settings, steady-state phase widths
    for (int it = 0; it < 12; it++) begin
      sel = 1'($urandom_range(0, 1));
      spd = 2'($urandom_range(0, 3));
      n   = (spd == 2'b00) ? $urandom_range(0, 3) : $urandom_range(0, 7);
      dly = $urandom_range(0, 3);
      wr(mkcfg(sel, n, dly, 1'b1));
      settle();
      measure(hi, lo);
      e = exp_half(sel, n, spd);
      chk(hi == e, "R1/R2/R5 high phase", hi, e);
      chk(lo == e, "R5 low phase 50% duty", lo, e);
    end

    // R3: zero divisor equals one
    spd = 2'b01;
    wr(mkcfg(1'b0, 0, 0, 1'b1)); settle(); measure(hi, lo);
    chk(hi == 5 && lo == 5, "R3 divisor 0 high", hi, 5);
    wr(mkcfg(1'b0, 1, 0, 1'b1)); settle(); measure(lo, e);
    chk(lo == hi, "R3 divisor 0 matches 1", hi, lo);

    // R6: phase delay in fast-pulse periods (period 10 cycles)
    wr(mkcfg(1'b0, 1, 0, 1'b1)); settle(); wait_rise(ok); ph0 = cyc % 10;
    wr(mkcfg(1'b0, 1, 1, 1'b1)); settle(); wait_rise(ok); ph1 = cyc % 10;
    wr(mkcfg(1'b0, 1, 3, 1'b1)); settle(); wait_rise(ok); ph3 = cyc % 10;
    chk((ph1 - ph0 + 10) % 10 == 1, "R6 delay 1", (ph1 - ph0 + 10) % 10, 1);
    chk((ph3 - ph0 + 10) % 10 == 3, "R6 delay 3", (ph3 - ph0 + 10) % 10, 3);

    // R7: speed change mid-high lands only at next rise
    spd = 2'b01;
    wr(mkcfg(1'b0, 2, 0, 1'b1)); settle();
    wait_rise(ok); hi = 1;
    repeat (3) begin @(negedge clk); if (tx_clk) hi++; end
    spd = 2'b10;
    for (int i = 0; i < LIM; i++) begin @(negedge clk); if (tx_clk) hi++; else break; end
    lo = 1;
    for (int i = 0; i < LIM; i++) begin @(negedge clk); if (!tx_clk) lo++; else break; end
    chk(hi == 10, "R7 running high keeps old width", hi, 10);
    chk(lo == 10, "R7 running low keeps old width", lo, 10);
    hi = 1;
    for (int i = 0; i < LIM; i++) begin @(negedge clk); if (tx_clk) hi++; else break; end
    chk(hi == 2, "R7 new speed from next rise", hi, 2);

    // R8 R9: enable at arbitrary points, full first pulse, valid timing
    spd = 2'b01;
    for (int k = 0; k < 4; k++) begin
      wr(mkcfg(1'b0, 2, 0, 1'b0));
      repeat (30 + $urandom_range(0, 19)) @(negedge clk);
      chk(!tx_clk && !clk_valid, "R4 gate off holds low", int'(tx_clk), 0);
      wr(mkcfg(1'b0, 2, 0, 1'b1));
      measure(hi, lo);
      chk(hi == 10, "R8 first pulse full width", hi, 10);
      chk(!clk_valid, "R9 valid low after first rise", int'(clk_valid), 0);
      chk(!clk_valid, "R9 valid low at second rise", int'(clk_valid), 0);
      @(negedge clk);
      chk(clk_valid, "R9 valid high after full period", int'(clk_valid), 1);
    end

    // R4 R8 R9: disable mid-pulse
    wait_rise(ok); hi = 1;
    wr_en = 1'b1; wr_data = mkcfg(1'b0, 2, 0, 1'b0);
    @(negedge clk); wr_en = 1'b0;
    chk(!clk_valid, "R9 valid drops with gate bit", int'(clk_valid), 0);
    for (int i = 0; i < LIM; i++) begin if (tx_clk) hi++; else break; @(negedge clk); end
    chk(hi == 10, "R8 last pulse full width", hi, 10);
    e = 0;
    repeat (1500) begin @(negedge clk); if (tx_clk) e++; end
    chk(e == 0, "R4 output stays low while off", e, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule